// File: doc/BRIEF.md
# PCIe Uncorrectable Error Logger

This block keeps the uncorrectable-error record of one PCI Express port. Each cycle a vector of single-cycle error pulses arrives on `err_i`, one bit per error kind. A per-bit detect mask decides which pulses count. Every counted pulse sets a sticky bit in the status register. The same pulse is then steered by its per-bit severity setting into one of two error classes: fatal, or non-fatal/correctable.

Each class owns two log registers. The first-error register holds the error or errors that arrived while it was empty. The next-error register gathers every later error of that class.

Software reads all registers directly from the output ports. It changes them through a single-cycle write port. Mask and severity are plain read/write registers. Status and the four log registers are cleared by writing ones. A soft reset restores mask and severity to their defaults. Status and log contents survive it, and only the power-on reset clears them.

Top module: `pcie_uerr_log`

## Requirements
- R1: An error pulse whose mask bit is 1 sets no status bit and no log bit.
- R2: An unmasked error pulse on an implemented bit sets that status bit at the next clock edge, and the bit stays set until it is cleared.
- R3: A recorded error with severity bit 1 is logged in the fatal registers. With severity bit 0 it is logged in the non-fatal registers. The severity value in force in the cycle of the pulse decides the class.
- R4: When a class's first-error register is zero, all errors of that class recorded in that cycle are placed in the first-error register, and the next-error register is unchanged.
- R5: When a class's first-error register is non-zero, errors of that class set the matching bits of that class's next-error register, and the first-error register is unchanged.
- R6: Writing data to the status register or to a log register clears the bits where the data is 1 and leaves the bits where it is 0. If a bit is set by an error and cleared by a write in the same cycle, the bit stays set.
- R7: Mask and severity are read/write registers. After reset the mask is all zero and the severity is 0x040010. A soft reset pulse restores both values.
- R8: Status and log registers are all zero after the power-on reset. They keep their contents through a soft reset.
- R9: Only bits 4 and 12 to 20 are implemented. All other bits of every register read as zero, and they ignore both writes and error pulses.
- R10: The unsupported-request error is bit 20 and the malformed-TLP error is bit 18. Write addresses are: 0 status, 1 mask, 2 severity, 3 fatal first, 4 fatal next, 5 non-fatal first, 6 non-fatal next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| soft_rst_i | input | 1 | Synchronous soft reset of mask and severity |
| err_i | input | 21 | Error event pulses, one bit per error kind |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 21 | Register write data |
| status_o | output | 21 | Sticky error status |
| mask_o | output | 21 | Detect mask |
| sev_o | output | 21 | Severity, 1 = fatal |
| fat_first_o | output | 21 | Fatal first-error log |
| fat_next_o | output | 21 | Fatal next-error log |
| nf_first_o | output | 21 | Non-fatal first-error log |
| nf_next_o | output | 21 | Non-fatal next-error log |

## Verification
Every register result of this block appears exactly one clock edge after its cause. An error pulse, a write or a soft reset presented in a cycle is visible on the outputs after the next rising edge, with no pipeline in between.

The bench drives each stimulus on a falling edge and holds it for one full cycle. It then compares all five status and log outputs on the following falling edge, which places every sample one edge after the stimulus and half a cycle away from any edge. Because each vector depends on the state left by the one before it, the expected values in the table are worked out as a running sequence starting from reset.

// File: rtl/uerr_pkg.sv
package uerr_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_STATUS    = 3'd0;
  localparam logic [ADDR_W-1:0] A_MASK      = 3'd1;
  localparam logic [ADDR_W-1:0] A_SEV       = 3'd2;
  localparam logic [ADDR_W-1:0] A_FAT_FIRST = 3'd3;
  localparam logic [ADDR_W-1:0] A_FAT_NEXT  = 3'd4;
  localparam logic [ADDR_W-1:0] A_NF_FIRST  = 3'd5;
  localparam logic [ADDR_W-1:0] A_NF_NEXT   = 3'd6;
  localparam int N_CLASS = 2;  // 0 = fatal, 1 = non-fatal
endpackage

// File: rtl/uerr_rw_reg.sv
module uerr_rw_reg
  import uerr_pkg::*;
#(
  parameter int               W       = 21,
  parameter logic [W-1:0]     IMPL    = '1,
  parameter logic [W-1:0]     RST_VAL = '0,
  parameter logic [ADDR_W-1:0] ADDR   = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [W-1:0]      wr_data_i,
  output logic [W-1:0]      q_o
);
  localparam logic [W-1:0] RST_EFF = RST_VAL & IMPL;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             q_o <= RST_EFF;
    else if (soft_rst_i)                     q_o <= RST_EFF;
    else if (wr_en_i && wr_addr_i == ADDR)   q_o <= wr_data_i & IMPL;
  end
endmodule

// File: rtl/uerr_class_log.sv
module uerr_class_log
  import uerr_pkg::*;
#(
  parameter int                W          = 21,
  parameter logic [W-1:0]      IMPL       = '1,
  parameter logic [ADDR_W-1:0] FIRST_ADDR = '0,
  parameter logic [ADDR_W-1:0] NEXT_ADDR  = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [W-1:0]      hit_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [W-1:0]      wr_data_i,
  output logic [W-1:0]      first_o,
  output logic [W-1:0]      next_o
);
  logic [W-1:0] first_keep, next_keep, first_d, next_d;

  always_comb begin
    first_keep = first_o;
    next_keep  = next_o;
    if (wr_en_i && wr_addr_i == FIRST_ADDR) first_keep = first_o & ~(wr_data_i & IMPL);
    if (wr_en_i && wr_addr_i == NEXT_ADDR)  next_keep  = next_o  & ~(wr_data_i & IMPL);
    // empty first register takes the whole batch; otherwise it goes to next
    if (first_keep == '0) begin
      first_d = hit_i;
      next_d  = next_keep;
    end else begin
      first_d = first_keep;
      next_d  = next_keep | hit_i;
    end
  end

  // sticky: power-on reset only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_o <= '0;
      next_o  <= '0;
    end else begin
      first_o <= first_d;
      next_o  <= next_d;
    end
  end
endmodule

// File: rtl/pcie_uerr_log.sv
module pcie_uerr_log
  import uerr_pkg::*;
#(
  parameter int           W        = 21,
  parameter logic [W-1:0] IMPL     = W'('h1FF010),
  parameter logic [W-1:0] MASK_RST = '0,
  parameter logic [W-1:0] SEV_RST  = W'('h040010)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic [W-1:0]      err_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [W-1:0]      wr_data_i,
  output logic [W-1:0]      status_o,
  output logic [W-1:0]      mask_o,
  output logic [W-1:0]      sev_o,
  output logic [W-1:0]      fat_first_o,
  output logic [W-1:0]      fat_next_o,
  output logic [W-1:0]      nf_first_o,
  output logic [W-1:0]      nf_next_o
);
  logic [W-1:0] hit, status_keep;
  logic [W-1:0] first_q [N_CLASS];
  logic [W-1:0] next_q  [N_CLASS];

  uerr_rw_reg #(.W(W), .IMPL(IMPL), .RST_VAL(MASK_RST), .ADDR(A_MASK)) u_mask (
    .clk_i, .rst_ni, .soft_rst_i, .wr_en_i, .wr_addr_i, .wr_data_i, .q_o(mask_o)
  );

  uerr_rw_reg #(.W(W), .IMPL(IMPL), .RST_VAL(SEV_RST), .ADDR(A_SEV)) u_sev (
    .clk_i, .rst_ni, .soft_rst_i, .wr_en_i, .wr_addr_i, .wr_data_i, .q_o(sev_o)
  );

  assign hit = err_i & ~mask_o & IMPL;

  always_comb begin
    status_keep = status_o;
    if (wr_en_i && wr_addr_i == A_STATUS) status_keep = status_o & ~(wr_data_i & IMPL);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_o <= '0;
    else         status_o <= status_keep | hit;
  end

  for (genvar g = 0; g < N_CLASS; g++) begin : g_class
    localparam logic [ADDR_W-1:0] FA = (g == 0) ? A_FAT_FIRST : A_NF_FIRST;
    localparam logic [ADDR_W-1:0] NA = (g == 0) ? A_FAT_NEXT  : A_NF_NEXT;
    logic [W-1:0] class_hit;
    assign class_hit = (g == 0) ? (hit & sev_o) : (hit & ~sev_o);

    uerr_class_log #(.W(W), .IMPL(IMPL), .FIRST_ADDR(FA), .NEXT_ADDR(NA)) u_log (
      .clk_i, .rst_ni, .hit_i(class_hit), .wr_en_i, .wr_addr_i, .wr_data_i,
      .first_o(first_q[g]), .next_o(next_q[g])
    );
  end

  assign fat_first_o = first_q[0];
  assign fat_next_o  = next_q[0];
  assign nf_first_o  = first_q[1];
  assign nf_next_o   = next_q[1];
endmodule

// File: rtl/uerr_log_chk.sv
module uerr_log_chk
  import uerr_pkg::*;
#(
  parameter int           W    = 21,
  parameter logic [W-1:0] IMPL = '1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [W-1:0]      status_o,
  input logic [W-1:0]      mask_o,
  input logic [W-1:0]      sev_o,
  input logic [W-1:0]      fat_first_o,
  input logic [W-1:0]      fat_next_o,
  input logic [W-1:0]      nf_first_o,
  input logic [W-1:0]      nf_next_o
);
  assert_masked_no_status_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_o & ~$past(status_o) & $past(mask_o)) == '0));

  assert_fatal_from_sev_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((fat_first_o | fat_next_o) & ~$past(fat_first_o | fat_next_o) & ~$past(sev_o)) == '0));

  assert_nonfatal_from_sev_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((nf_first_o | nf_next_o) & ~$past(nf_first_o | nf_next_o) & $past(sev_o)) == '0));

  assert_first_only_when_empty_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((fat_first_o & ~$past(fat_first_o)) != '0) |->
      ($past(fat_first_o) == '0 || $past(wr_en_i && wr_addr_i == A_FAT_FIRST)));

  assert_status_clear_by_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(status_o) & ~status_o) != '0) |-> $past(wr_en_i && wr_addr_i == A_STATUS));

  assert_reserved_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((status_o | mask_o | sev_o | fat_first_o | fat_next_o | nf_first_o | nf_next_o)
      & ~IMPL) == '0));
endmodule

bind pcie_uerr_log uerr_log_chk #(.W(W), .IMPL(IMPL)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
  .status_o(status_o), .mask_o(mask_o), .sev_o(sev_o),
  .fat_first_o(fat_first_o), .fat_next_o(fat_next_o),
  .nf_first_o(nf_first_o), .nf_next_o(nf_next_o)
);

// File: tb/tb_pcie_uerr_log.sv
module tb_pcie_uerr_log;
  localparam int CLK_PERIOD = 10;
  localparam int W = 21;
  localparam int NV = 17;

  typedef struct packed {
    logic         wr;
    logic [2:0]   addr;
    logic [W-1:0] data;
    logic [W-1:0] err;
    logic [W-1:0] st, ff, fn, nf, nn;
    logic [3:0]   req;
  } vec_t;

  // running sequence from reset; severity default 0x040010, mask 0
  localparam vec_t VECS [NV] = '{
    '{1'b0, 3'd0, 21'h0,      21'h100000, 21'h100000, 21'h0,      21'h0,      21'h100000, 21'h0,      4'd10}, // UR bit20 non-fatal
    '{1'b0, 3'd0, 21'h0,      21'h040000, 21'h140000, 21'h040000, 21'h0,      21'h100000, 21'h0,      4'd3},  // malformed bit18 fatal
    '{1'b0, 3'd0, 21'h0,      21'h100000, 21'h140000, 21'h040000, 21'h0,      21'h100000, 21'h100000, 4'd5},
    '{1'b0, 3'd0, 21'h0,      21'h001010, 21'h141010, 21'h040000, 21'h000010, 21'h100000, 21'h101000, 4'd3},
    '{1'b1, 3'd0, 21'h100000, 21'h0,      21'h041010, 21'h040000, 21'h000010, 21'h100000, 21'h101000, 4'd6},
    '{1'b1, 3'd5, 21'h100000, 21'h0,      21'h041010, 21'h040000, 21'h000010, 21'h0,      21'h101000, 4'd6},
    '{1'b0, 3'd0, 21'h0,      21'h006000, 21'h047010, 21'h040000, 21'h000010, 21'h006000, 21'h101000, 4'd4},
    '{1'b0, 3'd0, 21'h0,      21'h000003, 21'h047010, 21'h040000, 21'h000010, 21'h006000, 21'h101000, 4'd9},
    '{1'b1, 3'd1, 21'h008000, 21'h0,      21'h047010, 21'h040000, 21'h000010, 21'h006000, 21'h101000, 4'd7},
    '{1'b0, 3'd0, 21'h0,      21'h008000, 21'h047010, 21'h040000, 21'h000010, 21'h006000, 21'h101000, 4'd1},
    '{1'b1, 3'd2, 21'h080000, 21'h0,      21'h047010, 21'h040000, 21'h000010, 21'h006000, 21'h101000, 4'd7},
    '{1'b0, 3'd0, 21'h0,      21'h080000, 21'h0C7010, 21'h040000, 21'h080010, 21'h006000, 21'h101000, 4'd3},
    '{1'b1, 3'd3, 21'h1FFFFF, 21'h0,      21'h0C7010, 21'h0,      21'h080010, 21'h006000, 21'h101000, 4'd6},
    '{1'b0, 3'd0, 21'h0,      21'h010000, 21'h0D7010, 21'h0,      21'h080010, 21'h006000, 21'h111000, 4'd3},
    '{1'b0, 3'd0, 21'h0,      21'h0C0000, 21'h0D7010, 21'h080000, 21'h080010, 21'h006000, 21'h151000, 4'd4},
    '{1'b1, 3'd6, 21'h0,      21'h0,      21'h0D7010, 21'h080000, 21'h080010, 21'h006000, 21'h151000, 4'd6},
    '{1'b1, 3'd0, 21'h001000, 21'h001000, 21'h0D7010, 21'h080000, 21'h080010, 21'h006000, 21'h151000, 4'd6}
  };

  logic clk = 1'b0, rst_n = 1'b0, soft_rst = 1'b0, wr_en = 1'b0;
  logic [2:0]   wr_addr = '0;
  logic [W-1:0] err = '0, wr_data = '0;
  logic [W-1:0] status, mask, sev, fat_first, fat_next, nf_first, nf_next;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcie_uerr_log dut (
    .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst), .err_i(err),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .status_o(status), .mask_o(mask), .sev_o(sev),
    .fat_first_o(fat_first), .fat_next_o(fat_next),
    .nf_first_o(nf_first), .nf_next_o(nf_next)
  );

  function automatic string req_name(input logic [3:0] n);
    case (n)
      4'd1: return "R1";  4'd2: return "R2";  4'd3: return "R3";
      4'd4: return "R4";  4'd5: return "R5";  4'd6: return "R6";
      4'd7: return "R7";  4'd8: return "R8";  4'd9: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [W-1:0] act, exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state: R8 logs zero, R7 config defaults
    chk("R8", "status", status, '0);
    chk("R8", "fat_first", fat_first, '0);
    chk("R8", "nf_next", nf_next, '0);
    chk("R7", "mask", mask, '0);
    chk("R7", "sev", sev, 21'h040010);

    for (int i = 0; i < NV; i++) begin
      wr_en = VECS[i].wr; wr_addr = VECS[i].addr; wr_data = VECS[i].data; err = VECS[i].err;
      @(negedge clk);
      chk(req_name(VECS[i].req), $sformatf("v%0d status", i),    status,    VECS[i].st);
      chk(req_name(VECS[i].req), $sformatf("v%0d fat_first", i), fat_first, VECS[i].ff);
      chk(req_name(VECS[i].req), $sformatf("v%0d fat_next", i),  fat_next,  VECS[i].fn);
      chk(req_name(VECS[i].req), $sformatf("v%0d nf_first", i),  nf_first,  VECS[i].nf);
      chk(req_name(VECS[i].req), $sformatf("v%0d nf_next", i),   nf_next,   VECS[i].nn);
    end
    wr_en = 1'b0; err = '0;
    chk("R7", "mask after write", mask, 21'h008000);
    chk("R7", "sev after write", sev, 21'h080000);
    chk("R2", "status sticky", status, 21'h0D7010);

    // R9: reserved mask bits ignore writes
    wr_en = 1'b1; wr_addr = 3'd1; wr_data = 21'h1FFFFF;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R9", "mask reserved", mask, 21'h1FF010);

    // soft reset: R7 defaults back, R8 sticky kept
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    chk("R7", "mask soft", mask, '0);
    chk("R7", "sev soft", sev, 21'h040010);
    chk("R8", "status soft", status, 21'h0D7010);
    chk("R8", "fat_first soft", fat_first, 21'h080000);
    chk("R8", "nf_next soft", nf_next, 21'h151000);

    // R1 directed: all masked, burst of errors, nothing recorded
    wr_en = 1'b1; wr_addr = 3'd1; wr_data = 21'h1FFFFF;
    @(negedge clk);
    wr_en = 1'b0; err = 21'h1FFFFF;
    @(negedge clk);
    err = '0;
    chk("R1", "status masked", status, 21'h0D7010);
    chk("R1", "nf_first masked", nf_first, 21'h006000);

    // power-on reset clears sticky state
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8", "status por", status, '0);
    chk("R8", "fat_next por", fat_next, '0);
    chk("R8", "nf_next por", nf_next, '0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule